// File: doc/BRIEF.md
# Dual-Bank Phase-to-Sine Oscillator

This block is a numerically controlled oscillator for waveform synthesis. A phase accumulator adds a tuning word to itself once per clock, and the output frequency is the tuning word times the clock rate over 2^28. Two tuning banks and two phase-offset banks are loaded through a plain write port. Two select inputs choose which tuning word drives the accumulator and which offset shifts the phase. Either select can flip at any time. A bank change alters only the step size or the added offset, never the running accumulator, so the waveform does not jump.

The offset is added to the top bits of the accumulator, and the sum is a short phase word. A mode input chooses between two outputs. In one mode the phase word is rebuilt into an unsigned sine amplitude centred on mid-scale, using a quarter-wave table. In the other mode the upper phase bits are passed out as a sawtooth ramp. The phase adder, the table read and the output register are three pipeline stages.

Top module: `dds_sine_gen`

## Requirements
- R1: Synchronous reset clears the accumulator, both tuning words, both offsets and every pipeline stage, so `wave_o` reads 0 during reset and for the clocks after it until new data reaches the output. With no writes after reset, the accumulator stays at zero.
- R2: On each clock edge out of reset, the 28-bit accumulator becomes its old value plus the selected tuning word, modulo 2^28. Tuning words close to 2^28 make the phase run backwards through the wrap.
- R3: `tune_sel` = 0 selects tuning bank 0 and 1 selects bank 1. Changing it changes only the increment from that edge on, and the accumulator value is carried on unchanged.
- R4: The phase word is (accumulator bits 27..16 + selected offset) modulo 4096.
- R5: `offs_sel` = 0 selects offset bank 0 and 1 selects bank 1. The offset in use can change on any edge without touching the accumulator.
- R6: When `wr_en` is high, the edge writes `wr_data` into the bank given by `wr_addr`: 0 is tuning bank 0, 1 is tuning bank 1, 2 is offset bank 0, 3 is offset bank 1. An offset bank keeps only `wr_data[11:0]`, and the upper bits are ignored. The accumulator step at the writing edge still uses the old contents.
- R7: When `sine_en` = 0, `wave_o` is bits 11..2 of the phase word.
- R8: When `sine_en` = 1, `wave_o` is within 1 LSB of 511.5 + 511.5·sin(2π(p + 0.5)/4096), where p is the phase word.
- R9: In sine mode, the outputs for phase words p and p + 2048 add up to exactly 1023. For p < 1024, the outputs for p and 2047 − p are equal.
- R10: A select, mode or offset value sampled at edge n shows at `wave_o` after edge n + 2. An accumulator value reaches the output the same way, through three registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bank write strobe |
| wr_addr | input | 2 | Bank index for a write |
| wr_data | input | 28 | Write data (offset banks use bits 11..0) |
| tune_sel | input | 1 | Active tuning bank |
| offs_sel | input | 1 | Active offset bank |
| sine_en | input | 1 | 1: sine amplitude, 0: phase ramp |
| wave_o | output | 10 | Unsigned output sample |

## Verification
The bench builds the block with its default widths: a 28-bit accumulator, a 12-bit phase word and a 10-bit amplitude. At these widths a tuning word of 2^16 moves the phase word by exactly one table address per clock. One pass of 4096 clocks therefore visits every phase, and the symmetry of the rebuilt sine can be checked address by address. A word of 2^28 − 2^16 runs the accumulator backwards across the wrap. Because these widths are small, the bench can model the accumulator exactly with a wider integer and a mask.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // Bank index carried on the write port.
    typedef enum logic [1:0] {
        SEL_TUNE0 = 2'd0,
        SEL_TUNE1 = 2'd1,
        SEL_OFFS0 = 2'd2,
        SEL_OFFS1 = 2'd3
    } bank_addr_e;

    // Output shaping picked by the mode input.
    typedef enum logic {
        WAVE_RAMP = 1'b0,
        WAVE_SINE = 1'b1
    } wave_mode_e;

    // Rotation iterations used to build the quarter-wave table.
    localparam int     CORDIC_ITER = 16;
    localparam int     CORDIC_FRAC = 20;
    // Inverse gain 0.6072529 in CORDIC_FRAC fraction bits.
    localparam longint CORDIC_GAIN = 64'd636751;
    // pi in 30 fraction bits.
    localparam longint PI_Q30      = 64'd3373259426;

    // arctan(2^-i) in 30 fraction bits; small angles use arctan(x) ~ x.
    function automatic longint atan_q30(input int i);
        case (i)
            0:       atan_q30 = 64'd843314857;
            1:       atan_q30 = 64'd497837829;
            2:       atan_q30 = 64'd263043837;
            3:       atan_q30 = 64'd133525159;
            4:       atan_q30 = 64'd67021687;
            5:       atan_q30 = 64'd33543516;
            6:       atan_q30 = 64'd16775851;
            7:       atan_q30 = 64'd8388437;
            8:       atan_q30 = 64'd4194283;
            9:       atan_q30 = 64'd2097149;
            default: atan_q30 = longint'(1) <<< (30 - i);
        endcase
    endfunction

    // Magnitude of quarter-wave entry k, sampled at the bin centre
    // theta = 2*pi*(k + 0.5) / 2^ph_w. Returns floor((2^amp_w - 1)/2 * sin).
    function automatic int quarter_mag(input int k, input int ph_w, input int amp_w);
        longint x;
        longint y;
        longint z;
        longint xn;
        longint q;
        longint top;
        x = CORDIC_GAIN;
        y = 0;
        z = (longint'(2 * k + 1) * PI_Q30) >>> ph_w;
        for (int i = 0; i < CORDIC_ITER; i++) begin
            if (z >= 0) begin
                xn = x - (y >>> i);
                y  = y + (x >>> i);
                z  = z - atan_q30(i);
            end else begin
                xn = x + (y >>> i);
                y  = y - (x >>> i);
                z  = z + atan_q30(i);
            end
            x = xn;
        end
        q   = (y * ((longint'(1) <<< amp_w) - 1)) >>> (CORDIC_FRAC + 1);
        top = (longint'(1) <<< (amp_w - 1)) - 1;
        if (q < 0)   q = 0;
        if (q > top) q = top;
        return int'(q);
    endfunction

endpackage

// File: rtl/dds_tuning_regs.sv
module dds_tuning_regs
    import dds_pkg::*;
#(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_addr,
    input  logic [ACC_W-1:0]           wr_data,
    input  logic                       tune_sel,
    input  logic                       offs_sel,
    output logic [1:0][ACC_W-1:0]      tune_q,
    output logic [ACC_W-1:0]           step_o,
    output logic [PH_W-1:0]            offs_o
);

    localparam int NBANK = 2;

    logic [1:0][PH_W-1:0] offs_q;
    bank_addr_e           addr_e;

    assign addr_e = bank_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANK; b++) begin
                tune_q[b] <= '0;
                offs_q[b] <= '0;
            end
        end else if (wr_en) begin
            case (addr_e)
                SEL_TUNE0: tune_q[0] <= wr_data;
                SEL_TUNE1: tune_q[1] <= wr_data;
                SEL_OFFS0: offs_q[0] <= wr_data[PH_W-1:0];
                SEL_OFFS1: offs_q[1] <= wr_data[PH_W-1:0];
                default:   ;
            endcase
        end
    end

    // Selects act combinationally on the edge that samples them.
    always_comb begin
        step_o = tune_q[tune_sel];
        offs_o = offs_q[offs_sel];
    end

endmodule

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
    parameter int ACC_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] step_i,
    output logic [ACC_W-1:0] acc_o
);

    // Natural wrap modulo 2^ACC_W; bank switches never reload this register.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o <= '0;
        end else begin
            acc_o <= acc_o + step_i;
        end
    end

endmodule

// File: rtl/dds_phase_mod.sv
module dds_phase_mod
    import dds_pkg::*;
#(
    parameter int PH_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] acc_hi_i,
    input  logic [PH_W-1:0] offs_i,
    input  logic            sine_en_i,
    output logic [PH_W-1:0] ph_o,
    output wave_mode_e      mode_o
);

    // Stage 1: offset added modulo 2^PH_W on the truncated phase only.
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_o   <= '0;
            mode_o <= WAVE_RAMP;
        end else begin
            ph_o   <= acc_hi_i + offs_i;
            mode_o <= sine_en_i ? WAVE_SINE : WAVE_RAMP;
        end
    end

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut
    import dds_pkg::*;
#(
    parameter int PH_W  = 12,
    parameter int AMP_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PH_W-1:0]  ph_i,
    input  wave_mode_e       mode_i,
    output logic [AMP_W-1:0] wave_o
);

    localparam int QW     = PH_W - 2;
    localparam int QDEPTH = 1 << QW;
    localparam int MAGW   = AMP_W - 1;
    localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

    // Quarter-wave magnitudes computed at elaboration.
    logic [MAGW-1:0] quarter_tbl [QDEPTH];

    for (genvar k = 0; k < QDEPTH; k++) begin : g_quarter
        localparam int QV = quarter_mag(k, PH_W, AMP_W);
        assign quarter_tbl[k] = MAGW'(QV);
    end

    logic [QW-1:0] idx;
    logic          mirror;

    // Second quadrant of each half runs the table backwards.
    assign mirror = ph_i[PH_W-2];
    assign idx    = mirror ? ~ph_i[QW-1:0] : ph_i[QW-1:0];

    // Stage 2: table read plus the side information for rebuilding.
    logic [MAGW-1:0]  mag_q;
    logic             neg_q;
    logic [AMP_W-1:0] ramp_q;
    wave_mode_e       mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_q  <= '0;
            neg_q  <= 1'b0;
            ramp_q <= '0;
            mode_q <= WAVE_RAMP;
        end else begin
            mag_q  <= quarter_tbl[idx];
            neg_q  <= ph_i[PH_W-1];
            ramp_q <= ph_i[PH_W-1 -: AMP_W];
            mode_q <= mode_i;
        end
    end

    // Stage 3: reflect about mid-scale for the lower half-wave.
    logic [AMP_W-1:0] sine_val;

    always_comb begin
        if (neg_q) begin
            sine_val = (MID - AMP_W'(1)) - AMP_W'(mag_q);
        end else begin
            sine_val = MID + AMP_W'(mag_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_o <= '0;
        end else if (mode_q == WAVE_SINE) begin
            wave_o <= sine_val;
        end else begin
            wave_o <= ramp_q;
        end
    end

endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen
    import dds_pkg::*;
#(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12,
    parameter int AMP_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             tune_sel,
    input  logic             offs_sel,
    input  logic             sine_en,
    output logic [AMP_W-1:0] wave_o
);

    logic [1:0][ACC_W-1:0] tune_bank;
    logic [ACC_W-1:0]      step_sel;
    logic [PH_W-1:0]       offs_sel_w;
    logic [ACC_W-1:0]      acc;
    logic [PH_W-1:0]       ph_mod;
    wave_mode_e            mode_p1;

    dds_tuning_regs #(
        .ACC_W (ACC_W),
        .PH_W  (PH_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tune_sel (tune_sel),
        .offs_sel (offs_sel),
        .tune_q   (tune_bank),
        .step_o   (step_sel),
        .offs_o   (offs_sel_w)
    );

    dds_phase_accum #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .step_i (step_sel),
        .acc_o  (acc)
    );

    dds_phase_mod #(
        .PH_W (PH_W)
    ) u_pmod (
        .clk       (clk),
        .rst       (rst),
        .acc_hi_i  (acc[ACC_W-1 -: PH_W]),
        .offs_i    (offs_sel_w),
        .sine_en_i (sine_en),
        .ph_o      (ph_mod),
        .mode_o    (mode_p1)
    );

    dds_sine_lut #(
        .PH_W  (PH_W),
        .AMP_W (AMP_W)
    ) u_lut (
        .clk    (clk),
        .rst    (rst),
        .ph_i   (ph_mod),
        .mode_i (mode_p1),
        .wave_o (wave_o)
    );

endmodule

// File: rtl/dds_sine_gen_chk.sv
module dds_sine_gen_chk #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12,
    parameter int AMP_W = 10
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [1:0]            wr_addr,
    input logic [ACC_W-1:0]      wr_data,
    input logic                  sine_en,
    input logic [1:0][ACC_W-1:0] tune_bank,
    input logic [ACC_W-1:0]      step_sel,
    input logic [PH_W-1:0]       offs_sel_w,
    input logic [ACC_W-1:0]      acc,
    input logic [PH_W-1:0]       ph_mod,
    input logic [AMP_W-1:0]      wave_o
);

    // Edges out of reset since the last reset, saturating at 3.
    logic [1:0] live;

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= 2'd0;
        end else if (live != 2'd3) begin
            live <= live + 2'd1;
        end
    end

    assert_acc_cleared_R1: assert property (@(posedge clk) disable iff (rst)
        (live == 2'd0) |-> (acc == '0));

    assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (live != 2'd0) |-> (acc == ACC_W'($past(acc) + $past(step_sel))));

    assert_phase_add_R4: assert property (@(posedge clk) disable iff (rst)
        (live != 2'd0) |-> (ph_mod == PH_W'($past(acc[ACC_W-1 -: PH_W]) + $past(offs_sel_w))));

    assert_tune0_write_R6: assert property (@(posedge clk) disable iff (rst)
        (live != 2'd0 && $past(wr_en) && $past(wr_addr) == 2'd0) |-> (tune_bank[0] == $past(wr_data)));

    assert_tune1_write_R6: assert property (@(posedge clk) disable iff (rst)
        (live != 2'd0 && $past(wr_en) && $past(wr_addr) == 2'd1) |-> (tune_bank[1] == $past(wr_data)));

    assert_ramp_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (live == 2'd3 && !$past(sine_en, 3)) |-> (wave_o == $past(ph_mod[PH_W-1 -: AMP_W], 2)));

endmodule

bind dds_sine_gen dds_sine_gen_chk #(
    .ACC_W (ACC_W),
    .PH_W  (PH_W),
    .AMP_W (AMP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sine_en    (sine_en),
    .tune_bank  (tune_bank),
    .step_sel   (step_sel),
    .offs_sel_w (offs_sel_w),
    .acc        (acc),
    .ph_mod     (ph_mod),
    .wave_o     (wave_o)
);

// File: tb/dds_sine_gen_tb_top.sv
module dds_sine_gen_tb_top;

    localparam int ACC_W = 28;
    localparam int PH_W  = 12;
    localparam int AMP_W = 10;
    localparam longint ACC_MASK = (longint'(1) <<< ACC_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = 2'd0;
    logic [ACC_W-1:0] wr_data = '0;
    logic             tune_sel = 1'b0;
    logic             offs_sel = 1'b0;
    logic             sine_en = 1'b0;
    logic [AMP_W-1:0] wave_o;

    dds_sine_gen #(
        .ACC_W (ACC_W),
        .PH_W  (PH_W),
        .AMP_W (AMP_W)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tune_sel (tune_sel),
        .offs_sel (offs_sel),
        .sine_en  (sine_en),
        .wave_o   (wave_o)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_errs   = 0;
    string cur_tag  = "R1";
    bit    finished = 0;
    int    cycles   = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase history of the words entering the pipe.
    typedef struct {
        int ph;
        bit sine;
    } ent_t;

    ent_t   hist[$];
    longint m_acc = 0;
    longint m_tune0 = 0, m_tune1 = 0;
    int     m_offs0 = 0, m_offs1 = 0;
    int     seen[4096];
    bit     record_on = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_tune0 = 0; m_tune1 = 0; m_offs0 = 0; m_offs1 = 0;
            hist.delete();
        end else begin
            ent_t e;
            e.ph   = int'(((m_acc >> 16) + longint'(offs_sel ? m_offs1 : m_offs0)) & 4095);
            e.sine = sine_en;
            hist.push_back(e);
            if (hist.size() > 3) void'(hist.pop_front());
            m_acc = (m_acc + (tune_sel ? m_tune1 : m_tune0)) & ACC_MASK;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_tune0 = longint'(wr_data);
                    2'd1: m_tune1 = longint'(wr_data);
                    2'd2: m_offs0 = int'(wr_data) & 4095;
                    default: m_offs1 = int'(wr_data) & 4095;
                endcase
            end
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            if (hist.size() < 3) begin
                check(wave_o == '0, cur_tag, int'(wave_o), 0);
            end else if (!hist[0].sine) begin
                check(int'(wave_o) == (hist[0].ph >> 2), cur_tag == "R8" ? "R7" : cur_tag,
                      int'(wave_o), hist[0].ph >> 2);
            end else begin
                real e;
                real d;
                e = 511.5 + 511.5 * $sin(2.0 * 3.14159265358979 * (real'(hist[0].ph) + 0.5) / 4096.0);
                d = real'(int'(wave_o)) - e;
                check(d <= 1.0 && d >= -1.0, "R8", int'(wave_o), int'(e));
                if (record_on) seen[hist[0].ph] = int'(wave_o);
            end
        end
    end

    task automatic bank_write(input logic [1:0] a, input logic [ACC_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog (all requirements): actual=%0d expected=%0d cycles", cycles, 150000);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) seen[i] = -1;

        // R1: reset holds everything at zero.
        cur_tag = "R1";
        run(4);
        rst = 1'b0;
        run(8);

        // R6: load banks; offset bank 0 gets upper bits that must be dropped.
        cur_tag = "R6";
        bank_write(2'd0, 28'h0035000);
        bank_write(2'd1, 28'h0150000);
        bank_write(2'd2, 28'hFFFF123);
        bank_write(2'd3, 28'h0000ABC);
        run(20);

        // R2 / R7: steady accumulation through the ramp output.
        cur_tag = "R2";
        run(100);

        // R3: toggle the tuning bank while running.
        cur_tag = "R3";
        for (int i = 0; i < 20; i++) begin
            run(5);
            tune_sel = ~tune_sel;
        end

        // R5: toggle the offset bank while running.
        cur_tag = "R5";
        for (int i = 0; i < 20; i++) begin
            run(3);
            offs_sel = ~offs_sel;
        end

        // R2: negative-direction wrap and all-ones tuning word.
        cur_tag = "R2";
        tune_sel = 1'b0;
        bank_write(2'd0, 28'hFFF0000);
        run(100);
        bank_write(2'd0, 28'hFFFFFFF);
        run(30);

        // R10: frozen accumulator, flip the offset bank and time the response.
        cur_tag = "R10";
        bank_write(2'd0, 28'h0000000);
        offs_sel = 1'b0;
        run(6);
        begin
            logic [AMP_W-1:0] old_v;
            old_v = wave_o;
            offs_sel = 1'b1;
            @(negedge clk);
            check(wave_o == old_v, "R10", int'(wave_o), int'(old_v));
            @(negedge clk);
            check(wave_o == old_v, "R10", int'(wave_o), int'(old_v));
            @(negedge clk);
            check(wave_o != old_v, "R10", int'(wave_o), int'(old_v) + 1);
        end
        run(4);

        // R8: sweep every phase word once in sine mode.
        cur_tag = "R8";
        offs_sel = 1'b0;
        bank_write(2'd2, 28'h0000000);
        bank_write(2'd0, 28'h0010000);
        sine_en = 1'b1;
        run(4);
        record_on = 1;
        run(4100);
        record_on = 0;

        // R9: half-wave antisymmetry and quarter mirroring.
        for (int p = 0; p < 2048; p++) begin
            if (seen[p] >= 0 && seen[p + 2048] >= 0)
                check(seen[p] + seen[p + 2048] == 1023, "R9", seen[p] + seen[p + 2048], 1023);
            if (p < 1024 && seen[p] >= 0 && seen[2047 - p] >= 0)
                check(seen[p] == seen[2047 - p], "R9", seen[p], seen[2047 - p]);
        end
        check(seen[0] >= 0 && seen[4095] >= 0, "R9", seen[4095], 1);

        // R8: phase-modulated sine from the other banks.
        bank_write(2'd1, 28'h0123457);
        tune_sel = 1'b1;
        offs_sel = 1'b1;
        run(500);

        // R1: reset mid-run, banks cleared so the ramp stays at zero.
        cur_tag = "R1";
        @(negedge clk);
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        sine_en = 1'b0;
        run(12);
        check(wave_o == '0, "R1", int'(wave_o), 0);

        finished = 1;
        summary();
        $finish;
    end

endmodule